// File: doc/BRIEF.md
# Branch Target Address Generator

This block produces the next 14-bit program counter for the jump family of a small 4-bit controller. One request per cycle arrives with a branch-kind code, the address of the branch instruction, an immediate field and the two 8-bit register pairs that may serve as an indirect target. In the following cycle the block presents the computed target with a one-cycle strobe and the number of machine cycles the chosen form costs, so a sequencer or a timing checker downstream can use both.

Five forms are supported. The long form replaces the whole counter. The block form keeps the top two counter bits and takes the rest from a 12-bit immediate, so control stays within the current 4K region. The two register forms keep the top six counter bits and take the low byte from either pair, so control stays within the current 256-word page. The one-byte short form adds a signed displacement to the address just past the branch and wraps at the 14-bit boundary. Any preserved upper bits come from the address of the branch itself, never from an incremented copy.

Top module: `brgen_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, `valid_o` is 0, `pc_o` is 0 and `cycles_o` is 0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle in which `req_i` was 1 with `kind_i` in 0..4; kind codes 5, 6 and 7 give no strobe and leave `pc_o` and `cycles_o` unchanged.
- R3: Kind 0 (long form): `pc_o` equals `imm_i[13:0]` and `cycles_o` is 3.
- R4: Kind 1 (block form): `pc_o` equals `{pc_i[13:12], imm_i[11:0]}` of the request and `cycles_o` is 2.
- R5: Kind 2 (short form): `pc_o` equals `pc_i + 1 + sign_extend(imm_i[5:0])` taken modulo 2^14, and `cycles_o` is 2.
- R6: Kind 3 (first pair indirect): `pc_o` equals `{pc_i[13:8], de_i}` of the request and `cycles_o` is 3.
- R7: Kind 4 (second pair indirect): `pc_o` equals `{pc_i[13:8], xa_i}` of the request and `cycles_o` is 3.
- R8: In any cycle where `valid_o` is 0, `pc_o` and `cycles_o` keep the values of the previous cycle.
- R9: The short form wraps across both ends of the address space: a branch at 0x3FFF with displacement +1 targets 0x0001, and a branch at 0x0000 with displacement -32 targets 0x3FE1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe for one branch |
| kind_i | input | 3 | Branch form: 0 long, 1 block, 2 short, 3 first pair, 4 second pair |
| pc_i | input | 14 | Address of the branch instruction |
| imm_i | input | 14 | Immediate field (full address, 12-bit offset or 6-bit displacement) |
| de_i | input | 8 | First register pair |
| xa_i | input | 8 | Second register pair |
| pc_o | output | 14 | Computed target address |
| valid_o | output | 1 | One-cycle strobe marking a fresh target |
| cycles_o | output | 2 | Machine cycles of the chosen form |

## Verification
The properties assume every input is a known value at each rising edge while reset is high and that reset is low at the first edge; the stimulus drives all inputs from the falling edge, starting from defined values, and holds reset low for several cycles first. They also assume the immediate carries the short-form displacement in its low six bits with the upper bits free, and the stimulus exercises this by filling those upper bits with random data during short-form requests. Illegal kind codes and idle cycles are mixed between requests, including back-to-back strobes, so the hold rule sees every neighbour.

// File: rtl/brgen_pkg.sv
package brgen_pkg;

    localparam int unsigned KIND_W = 3;
    localparam int unsigned CYC_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_LONG  = 3'd0,
        KIND_BLOCK = 3'd1,
        KIND_SHORT = 3'd2,
        KIND_PAIR0 = 3'd3,
        KIND_PAIR1 = 3'd4
    } brgen_kind_e;

    function automatic logic [CYC_W-1:0] cost_of(input logic [KIND_W-1:0] k);
        case (k)
            KIND_LONG:  cost_of = 2'd3;
            KIND_BLOCK: cost_of = 2'd2;
            KIND_SHORT: cost_of = 2'd2;
            KIND_PAIR0: cost_of = 2'd3;
            KIND_PAIR1: cost_of = 2'd3;
            default:    cost_of = 2'd0;
        endcase
    endfunction

    function automatic logic is_legal(input logic [KIND_W-1:0] k);
        is_legal = (k <= KIND_PAIR1);
    endfunction

endpackage

// File: rtl/brgen_splice.sv
module brgen_splice #(
    parameter int unsigned PC_W   = 14,
    parameter int unsigned KEEP_W = 2,
    localparam int unsigned LOW_W = PC_W - KEEP_W
) (
    input  logic [PC_W-1:0]  base_i,
    input  logic [LOW_W-1:0] low_i,
    output logic [PC_W-1:0]  tgt_o
);

    // Upper bits stay with the branch's own page or block.
    always_comb begin
        tgt_o = {base_i[PC_W-1:LOW_W], low_i};
    end

endmodule

// File: rtl/brgen_reladd.sv
module brgen_reladd #(
    parameter int unsigned PC_W   = 14,
    parameter int unsigned DISP_W = 6,
    parameter int unsigned STEP   = 1
) (
    input  logic [PC_W-1:0]   base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]   tgt_o
);

    localparam int unsigned EXT_W = PC_W - DISP_W;
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic [PC_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        // Sum truncates to PC_W bits, wrapping at the address space edge.
        tgt_o    = base_i + STEP_V + disp_ext;
    end

endmodule

// File: rtl/brgen_top.sv
module brgen_top #(
    parameter int unsigned PC_W     = 14,
    parameter int unsigned BLK_KEEP = 2,
    parameter int unsigned PG_KEEP  = 6,
    parameter int unsigned DISP_W   = 6,
    parameter int unsigned PAIR_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_i,
    input  logic [brgen_pkg::KIND_W-1:0]   kind_i,
    input  logic [PC_W-1:0]                pc_i,
    input  logic [PC_W-1:0]                imm_i,
    input  logic [PAIR_W-1:0]              de_i,
    input  logic [PAIR_W-1:0]              xa_i,
    output logic [PC_W-1:0]                pc_o,
    output logic                           valid_o,
    output logic [brgen_pkg::CYC_W-1:0]    cycles_o
);

    import brgen_pkg::*;

    localparam int unsigned BLK_LOW = PC_W - BLK_KEEP;
    localparam int unsigned NPAIR   = 2;

    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [CYC_W-1:0] cyc;
    } out_t;

    logic [PC_W-1:0]   tgt_block;
    logic [PC_W-1:0]   tgt_short;
    logic [PAIR_W-1:0] pair_val [NPAIR];
    logic [PC_W-1:0]   tgt_pair [NPAIR];

    assign pair_val[0] = de_i;
    assign pair_val[1] = xa_i;

    brgen_splice #(.PC_W(PC_W), .KEEP_W(BLK_KEEP)) u_block (
        .base_i (pc_i),
        .low_i  (imm_i[BLK_LOW-1:0]),
        .tgt_o  (tgt_block)
    );

    generate
        for (genvar g = 0; g < NPAIR; g++) begin : g_pair
            brgen_splice #(.PC_W(PC_W), .KEEP_W(PG_KEEP)) u_page (
                .base_i (pc_i),
                .low_i  (pair_val[g]),
                .tgt_o  (tgt_pair[g])
            );
        end
    endgenerate

    brgen_reladd #(.PC_W(PC_W), .DISP_W(DISP_W), .STEP(1)) u_short (
        .base_i (pc_i),
        .disp_i (imm_i[DISP_W-1:0]),
        .tgt_o  (tgt_short)
    );

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (req_i && is_legal(kind_i)) begin
            out_d.valid = 1'b1;
            out_d.cyc   = cost_of(kind_i);
            case (brgen_kind_e'(kind_i))
                KIND_LONG:  out_d.pc = imm_i;
                KIND_BLOCK: out_d.pc = tgt_block;
                KIND_SHORT: out_d.pc = tgt_short;
                KIND_PAIR0: out_d.pc = tgt_pair[0];
                KIND_PAIR1: out_d.pc = tgt_pair[1];
                default:    out_d.pc = out_q.pc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pc_o     = out_q.pc;
    assign valid_o  = out_q.valid;
    assign cycles_o = out_q.cyc;

endmodule

// File: rtl/brgen_chk.sv
module brgen_chk #(
    parameter int unsigned PC_W   = 14,
    parameter int unsigned DISP_W = 6,
    parameter int unsigned PAIR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [2:0]        kind_i,
    input logic [PC_W-1:0]   pc_i,
    input logic [PC_W-1:0]   imm_i,
    input logic [PAIR_W-1:0] de_i,
    input logic [PAIR_W-1:0] xa_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              valid_o,
    input logic [1:0]        cycles_o
);

    logic [PC_W-1:0] next_addr;
    logic [PC_W-1:0] disp_full;
    assign next_addr = pc_i + PC_W'(1);
    assign disp_full = PC_W'($signed(imm_i[DISP_W-1:0]));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && pc_o == '0 && cycles_o == 2'd0));

    assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(req_i) && $past(kind_i) <= 3'd4));

    assert_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd0) |=> (valid_o && pc_o == $past(imm_i) && cycles_o == 2'd3));

    assert_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd1) |=> (valid_o && cycles_o == 2'd2
            && pc_o[PC_W-1:PC_W-2] == $past(pc_i[PC_W-1:PC_W-2])
            && pc_o[PC_W-3:0] == $past(imm_i[PC_W-3:0])));

    assert_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd2) |=> (valid_o && cycles_o == 2'd2
            && pc_o - $past(next_addr) == $past(disp_full)));

    assert_pair0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd3) |=> (valid_o && cycles_o == 2'd3
            && pc_o[PAIR_W-1:0] == $past(de_i)
            && pc_o[PC_W-1:PAIR_W] == $past(pc_i[PC_W-1:PAIR_W])));

    assert_pair1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd4) |=> (valid_o && cycles_o == 2'd3
            && pc_o[PAIR_W-1:0] == $past(xa_i)
            && pc_o[PC_W-1:PAIR_W] == $past(pc_i[PC_W-1:PAIR_W])));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(pc_o) && $stable(cycles_o)));

endmodule

bind brgen_top brgen_chk #(.PC_W(PC_W), .DISP_W(DISP_W), .PAIR_W(PAIR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .kind_i   (kind_i),
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .de_i     (de_i),
    .xa_i     (xa_i),
    .pc_o     (pc_o),
    .valid_o  (valid_o),
    .cycles_o (cycles_o)
);

// File: tb/brgen_top_tb.sv
`timescale 1ns/1ps
module brgen_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  kind_i = 3'd0;
    logic [13:0] pc_i = '0;
    logic [13:0] imm_i = '0;
    logic [7:0]  de_i = '0;
    logic [7:0]  xa_i = '0;
    logic [13:0] pc_o;
    logic        valid_o;
    logic [1:0]  cycles_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    exp_pc = 0;
    int    exp_cyc = 0;
    bit    exp_valid = 0;
    string exp_tag = "R1";

    always #2 clk = ~clk;

    brgen_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
        .pc_i(pc_i), .imm_i(imm_i), .de_i(de_i), .xa_i(xa_i),
        .pc_o(pc_o), .valid_o(valid_o), .cycles_o(cycles_o)
    );

    task automatic compare();
        checks++;
        if (valid_o !== exp_valid || int'(pc_o) != exp_pc || int'(cycles_o) != exp_cyc) begin
            errors++;
            $display("FAIL %s: got valid=%0b pc=%h cyc=%0d, want valid=%0b pc=%h cyc=%0d",
                     exp_tag, valid_o, pc_o, cycles_o, exp_valid, exp_pc[13:0], exp_cyc);
        end
    endtask

    // Reference: what the outputs must show one edge after these inputs.
    task automatic step(input bit rq, input int k, input int pc, input int imm,
                        input int de, input int xa, input string tag);
        int d;
        @(negedge clk);
        compare();
        req_i = rq; kind_i = 3'(k); pc_i = 14'(pc); imm_i = 14'(imm);
        de_i = 8'(de); xa_i = 8'(xa);
        if (rq && k <= 4) begin
            exp_valid = 1;
            case (k)
                0: begin exp_pc = imm & 'h3FFF; exp_cyc = 3; end
                1: begin exp_pc = (pc & 'h3000) | (imm & 'h0FFF); exp_cyc = 2; end
                2: begin
                    d = imm & 63;
                    if (d >= 32) d = d - 64;
                    exp_pc = (pc + 1 + d) & 'h3FFF; exp_cyc = 2;
                end
                3: begin exp_pc = (pc & 'h3F00) | (de & 'hFF); exp_cyc = 3; end
                default: begin exp_pc = (pc & 'h3F00) | (xa & 'hFF); exp_cyc = 3; end
            endcase
            exp_tag = tag;
        end else begin
            exp_valid = 0;
            exp_tag = (rq) ? "R2" : "R8";
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2: got hung run, want completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                      // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1");   // R1 first cycle after reset
        step(1, 0, 'h1234, 'h2ABC, 0, 0, "R3");
        step(1, 0, 'h0000, 'h3FFF, 0, 0, "R3");
        step(1, 1, 'h2F00, 'h3123, 0, 0, "R4");
        step(1, 1, 'h3FFF, 'h0000, 0, 0, "R4");
        step(0, 1, 'h1111, 'h0222, 0, 0, "R8");
        step(1, 2, 'h0100, 'h0005, 0, 0, "R5");
        step(1, 2, 'h0100, 'h3FF0, 0, 0, "R5");
        step(1, 2, 'h3FFF, 'h0001, 0, 0, "R9");
        step(1, 2, 'h0000, 'h0020, 0, 0, "R9");
        step(1, 3, 'h25C7, 0, 'h5A, 'hA5, "R6");
        step(1, 4, 'h25C7, 0, 'h5A, 'hA5, "R7");
        step(1, 5, 'h0FFF, 'h1111, 'h11, 'h22, "R2");
        step(1, 6, 'h0FFF, 'h1111, 'h11, 'h22, "R2");
        step(1, 7, 'h0FFF, 'h1111, 'h11, 'h22, "R2");
        step(1, 4, 'h3F00, 0, 'h00, 'hFF, "R7");
        step(0, 3, 'h3F00, 0, 'h44, 'h55, "R8");
        for (int i = 0; i < 400; i++) begin
            int k = int'($urandom_range(0, 7));
            string t;
            case (k)
                0: t = "R3"; 1: t = "R4"; 2: t = "R5";
                3: t = "R6"; 4: t = "R7"; default: t = "R2";
            endcase
            step(bit'($urandom_range(0, 3) != 0), k, int'($urandom_range(0, 'h3FFF)),
                 int'($urandom_range(0, 'h3FFF)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), t);
        end
        step(0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, "R8");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule